// File: doc/BRIEF.md
# Sync-byte baud lock controller

This controller sits on the receiving side of a serial link whose bit rate is not known in advance. After reset it is in hunt mode. Normal reception is off, and the controller times the reference byte 0x7F directly on the incoming line to learn the bit period in clock cycles. When a measurement looks plausible, it asks a UART transmitter to send an acknowledge byte. Once that byte has been handed over, it enters locked mode and presents the measured period to a standard UART receiver.

While locked, the controller supervises the link. Each valid byte from the UART restarts an inactivity timer. A reference byte that arrives while locked is answered with a negative acknowledge, and the lock is kept. Either a reported exchange failure or an expired timer returns the controller to hunt mode, where it waits for the next reference byte. The UART data path itself is outside the block. The block sees only the raw line, the UART's received-byte strobe and data, a failure flag, and a request/accept handshake with the transmitter.

Top module: `baud_lock_ctrl`

## Requirements
- R1: After reset, `locked_o` is 0, `period_o` is 0 and `tx_req_o` is 0.
- R2: On an accepted reference byte, `period_o` becomes the number of clock cycles between the falling edge of the start bit and the falling edge of data bit 7, divided by 8 and truncated. On the line the reference byte is a low start bit, seven high bits, a low bit 7 and a high stop bit. The decision is taken only once the line has returned high for the stop bit.
- R3: A measurement is accepted only if 4·w lies in [3·p, 5·p], where w is the width of the start low pulse and p is the computed period. Any other measurement leaves the block unlocked and raises no request.
- R4: After acceptance, the block requests byte 0x06 (acknowledge). `locked_o` rises two cycles after the cycle in which the transmitter accepts that byte, and stays low before then.
- R5: A request is a level on `tx_req_o` that rises on a single clock edge. It stays high with `tx_data_o` unchanged until a cycle with `tx_ready_i` high, and is low in the following cycle.
- R6: While locked, a `rx_valid_i` cycle carrying 0x7F raises a request for byte 0x15 (negative acknowledge) in the next cycle, and the block stays locked. If a request is already pending, the new one is dropped.
- R7: While locked, `locked_o` stays high for exactly TIMEOUT cycles after lock entry or after the last `rx_valid_i` cycle, and then falls, as long as no further valid byte arrives.
- R8: While locked, `exch_fail_i` makes `locked_o` low in the next cycle, and no negative acknowledge is raised in that cycle.
- R9: In hunt mode, `rx_valid_i` and `rx_data_i` have no effect. While locked, activity on `rx_i` neither changes `period_o` nor raises a request.
- R10: A measurement that sees no awaited edge within 2^CNT_W−1 cycles is abandoned. Measurement then restarts on the next start edge after the line is high.
- R11: `period_o` keeps its last locked value after the lock is lost, until the next accepted measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Raw serial line, idle high |
| rx_valid_i | input | 1 | UART reports a correctly received byte |
| rx_data_i | input | 8 | Byte reported with `rx_valid_i` |
| exch_fail_i | input | 1 | Higher layer reports a failed exchange |
| tx_ready_i | input | 1 | Transmitter takes the pending byte |
| tx_req_o | output | 1 | Byte send request, held until accepted |
| tx_data_o | output | 8 | Byte to send: 0x06 or 0x15 |
| locked_o | output | 1 | Locked mode; UART reception enabled |
| period_o | output | CNT_W-3 | Measured bit period in clock cycles |

## Verification
The bound checker covers, on every cycle, the properties that can be seen at the edges of the block. These are the request hold (R5), the allowed reply codes, the acknowledge-then-lock order (R4), a drop of the lock on a failure (R8), a stable period while locked, and an inactivity window counted in the checker (R7). Only the bench scenarios can show the measurement arithmetic and the ±25% acceptance boundaries (R2, R3). The same holds for the abandoned measurement after a noisy byte (R10), for the line being ignored while locked (R9), and for the dropped second negative acknowledge (R6). Each of these needs a particular waveform followed by a port reading.

// File: rtl/bbl_pkg.sv
package bbl_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_ACK, ST_ACKW, ST_SYNC} link_st_t;
  typedef enum logic [2:0] {M_IDLE, M_ARM, M_LOW, M_HIGH, M_BIT7} meas_st_t;
  localparam logic [7:0] REF_BYTE  = 8'h7F;
  localparam logic [7:0] ACK_BYTE  = 8'h06;
  localparam logic [7:0] NACK_BYTE = 8'h15;
endpackage

// File: rtl/bbl_line_sync.sv
module bbl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[STAGES-2:0], d_i};
  end

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/bbl_ref_timer.sv
module bbl_ref_timer
  import bbl_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PER_W = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             line_i,
  output logic             done_o,
  output logic             ok_o,
  output logic [PER_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_st_t         mode;
  logic             prev_q;
  logic [CNT_W-1:0] cnt, wid, span;
  logic             fall, rise, width_ok;
  logic [CNT_W+1:0] w4, p3, p5;

  assign fall = prev_q & ~line_i;
  assign rise = ~prev_q & line_i;
  assign period_o = span[CNT_W-1:3];

  // start pulse must be within a quarter period of the computed bit time
  always_comb begin
    w4 = {wid, 2'b00};
    p3 = {5'b0, period_o} + {4'b0, period_o, 1'b0};
    p5 = {5'b0, period_o} + {3'b0, period_o, 2'b00};
    width_ok = (w4 >= p3) && (w4 <= p5);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      mode   <= M_IDLE;
      cnt    <= '0;
      wid    <= '0;
      span   <= '0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
    end else begin
      prev_q <= line_i;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      if (!en_i) begin
        mode <= M_IDLE;
      end else begin
        case (mode)
          M_IDLE: if (line_i) mode <= M_ARM;
          M_ARM: if (fall) begin
            mode <= M_LOW;
            cnt  <= CNT_W'(1);
          end
          default: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) begin
              mode <= M_IDLE;
            end else if (mode == M_LOW && rise) begin
              wid  <= cnt;
              mode <= M_HIGH;
            end else if (mode == M_HIGH && fall) begin
              span <= cnt;
              mode <= M_BIT7;
            end else if (mode == M_BIT7 && rise) begin
              done_o <= 1'b1;
              ok_o   <= width_ok;
              mode   <= M_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bbl_watchdog.sv
module bbl_watchdog #(
  parameter int TIMEOUT = 100000,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT - 1);
  logic [TW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || !active_i || kick_i) left <= RELOAD;
    else if (left != '0)            left <= left - 1'b1;
  end

  assign expire_o = active_i && !kick_i && (left == '0);
endmodule

// File: rtl/bbl_tx_slot.sv
module bbl_tx_slot (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       ready_i,
  output logic       req_o,
  output logic [7:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      data_o <= '0;
    end else if (load_i) begin
      req_o  <= 1'b1;
      data_o <= data_i;
    end else if (req_o && ready_i) begin
      req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_lock_ctrl.sv
module baud_lock_ctrl
  import bbl_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TIMEOUT     = 100000,
  parameter int SYNC_STAGES = 2,
  localparam int PER_W = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             exch_fail_i,
  input  logic             tx_ready_i,
  output logic             tx_req_o,
  output logic [7:0]       tx_data_o,
  output logic             locked_o,
  output logic [PER_W-1:0] period_o
);
  link_st_t         st, st_n;
  logic             line_s, m_done, m_ok, expire, load;
  logic [7:0]       load_data;
  logic [PER_W-1:0] m_period;

  bbl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(rx_i), .q_o(line_s));

  bbl_ref_timer #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .en_i(st == ST_HUNT), .line_i(line_s),
    .done_o(m_done), .ok_o(m_ok), .period_o(m_period));

  bbl_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk(clk), .rst(rst), .active_i(st == ST_SYNC), .kick_i(rx_valid_i),
    .expire_o(expire));

  bbl_tx_slot u_tx (
    .clk(clk), .rst(rst), .load_i(load), .data_i(load_data),
    .ready_i(tx_ready_i), .req_o(tx_req_o), .data_o(tx_data_o));

  always_comb begin
    st_n      = st;
    load      = 1'b0;
    load_data = ACK_BYTE;
    case (st)
      ST_HUNT: if (m_done && m_ok) st_n = ST_ACK;
      ST_ACK: if (!tx_req_o) begin
        load = 1'b1;
        st_n = ST_ACKW;
      end
      ST_ACKW: if (!tx_req_o) st_n = ST_SYNC;
      default: begin
        if (exch_fail_i || expire) begin
          st_n = ST_HUNT;
        end else if (rx_valid_i && rx_data_i == REF_BYTE && !tx_req_o) begin
          load      = 1'b1;
          load_data = NACK_BYTE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      period_o <= '0;
    end else begin
      st <= st_n;
      if (st == ST_HUNT && m_done && m_ok) period_o <= m_period;
    end
  end

  assign locked_o = (st == ST_SYNC);
endmodule

// File: rtl/bbl_lock_checker.sv
module bbl_lock_checker #(
  parameter int TIMEOUT = 100000,
  parameter int PER_W   = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid_i,
  input logic             exch_fail_i,
  input logic             tx_ready_i,
  input logic             tx_req_o,
  input logic [7:0]       tx_data_o,
  input logic             locked_o,
  input logic [PER_W-1:0] period_o
);
  logic [31:0] quiet;

  always_ff @(posedge clk) begin
    if (rst)                         quiet <= '0;
    else if (locked_o && !rx_valid_i) quiet <= quiet + 1;
    else                             quiet <= '0;
  end

  p_req_held_r5: assert property (@(posedge clk) disable iff (rst)
    tx_req_o && !tx_ready_i |=> tx_req_o && $stable(tx_data_o));
  p_req_drops_r5: assert property (@(posedge clk) disable iff (rst)
    tx_req_o && tx_ready_i |=> !tx_req_o);
  p_codes_r6: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> (tx_data_o == 8'h06 || tx_data_o == 8'h15));
  p_ack_first_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(tx_req_o && tx_ready_i && tx_data_o == 8'h06, 2));
  p_fail_unlock_r8: assert property (@(posedge clk) disable iff (rst)
    locked_o && exch_fail_i |=> !locked_o && !$rose(tx_req_o));
  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> quiet < TIMEOUT);
  p_period_hold_r11: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> $stable(period_o));
endmodule

bind baud_lock_ctrl bbl_lock_checker #(.TIMEOUT(TIMEOUT), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid_i(rx_valid_i), .exch_fail_i(exch_fail_i),
  .tx_ready_i(tx_ready_i), .tx_req_o(tx_req_o), .tx_data_o(tx_data_o),
  .locked_o(locked_o), .period_o(period_o));

// File: tb/baud_lock_ctrl_bench.sv
module baud_lock_ctrl_bench;
  localparam int CW  = 12;
  localparam int TMO = 600;
  localparam int PW  = CW - 3;

  logic clk = 1'b0, rst = 1'b1, rx = 1'b1, rx_valid = 1'b0, fail = 1'b0, ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_req, locked;
  logic [7:0] tx_data;
  logic [PW-1:0] period;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  baud_lock_ctrl #(.CNT_W(CW), .TIMEOUT(TMO)) u_baud_lock_ctrl (
    .clk(clk), .rst(rst), .rx_i(rx), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .exch_fail_i(fail), .tx_ready_i(ready), .tx_req_o(tx_req), .tx_data_o(tx_data),
    .locked_o(locked), .period_o(period));

  // behavioural reference: mode 0 hunt, 1 ack, 2 ack-wait, 3 locked
  int r1, rs, rq, mm, mc, mw, mt, mdone, mok, mode, per, req, dat, tmr;
  always @(posedge clk) begin
    int o_rs, o_rq, o_done, o_ok, o_span, o_busy, o_mode, o_tmr, fall, rise, p, ld, ldd;
    if (rst) begin
      r1 = 1; rs = 1; rq = 1; mm = 0; mc = 0; mw = 0; mt = 0; mdone = 0; mok = 0;
      mode = 0; per = 0; req = 0; dat = 0; tmr = TMO - 1;
    end else begin
      o_rs = rs; o_rq = rq; o_done = mdone; o_ok = mok; o_span = mt;
      o_busy = req; o_mode = mode; o_tmr = tmr;
      fall = (o_rq == 1 && o_rs == 0); rise = (o_rq == 0 && o_rs == 1);
      rq = o_rs; rs = r1; r1 = rx;
      mdone = 0; mok = 0;
      if (o_mode != 0) mm = 0;
      else if (mm == 0) begin if (o_rs == 1) mm = 1; end
      else if (mm == 1) begin if (fall) begin mm = 2; mc = 1; end end
      else begin
        int c;
        c = mc; mc = (mc + 1) % (1 << CW);
        if (c == (1 << CW) - 1) mm = 0;
        else if (mm == 2 && rise) begin mw = c; mm = 3; end
        else if (mm == 3 && fall) begin mt = c; mm = 4; end
        else if (mm == 4 && rise) begin
          p = mt / 8; mdone = 1; mok = (4 * mw >= 3 * p) && (4 * mw <= 5 * p); mm = 0;
        end
      end
      if (o_mode != 3 || rx_valid) tmr = TMO - 1;
      else if (tmr > 0) tmr = tmr - 1;
      ld = 0; ldd = 0;
      case (o_mode)
        0: if (o_done && o_ok) begin mode = 1; per = o_span / 8; end
        1: if (!o_busy) begin ld = 1; ldd = 8'h06; mode = 2; end
        2: if (!o_busy) mode = 3;
        default: if (fail || (!rx_valid && o_tmr == 0)) mode = 0;
                 else if (rx_valid && rx_data == 8'h7F && !o_busy) begin ld = 1; ldd = 8'h15; end
      endcase
      if (ld) begin req = 1; dat = ldd; end
      else if (o_busy && ready) req = 0;
    end
  end

  always @(negedge clk) if (!rst && !finished) begin
    nchk++;
    if (locked !== (mode == 3) || period !== PW'(per) || tx_req !== (req == 1) || tx_data !== 8'(dat)) begin
      nfail++;
      $display("FAIL R4/R5/R7/R8 model compare: actual lk=%0d per=%0d req=%0d dat=%0h expected lk=%0d per=%0d req=%0d dat=%0h",
               locked, period, tx_req, tx_data, mode == 3, per, req, dat);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask
  task automatic seg(input logic lvl, input int n); rx = lvl; wait_n(n); endtask
  task automatic send_ref(input int lo1, input int hi, input int lo2, input int stp);
    seg(0, lo1); seg(1, hi); seg(0, lo2); seg(1, stp);
  endtask
  task automatic send_byte(input logic [7:0] b, input int bt);
    seg(0, bt);
    for (int i = 0; i < 8; i++) seg(b[i], bt);
    seg(1, bt);
  endtask
  task automatic give_ready; ready = 1; wait_n(1); ready = 0; endtask
  task automatic give_valid(input logic [7:0] d); rx_valid = 1; rx_data = d; wait_n(1); rx_valid = 0; endtask
  task automatic give_fail; fail = 1; wait_n(1); fail = 0; endtask
  task automatic accept_ack(input int exp_per, input string tag);
    chk({tag, " ack requested"}, tx_req, 1);
    chk("R4 ack code 0x06", tx_data, 8'h06);
    chk("R4 not locked before ack taken", locked, 0);
    give_ready;
    chk("R5 request drops after accept", tx_req, 0);
    chk("R4 still unlocked one cycle after accept", locked, 0);
    wait_n(1);
    chk("R4 locked two cycles after accept", locked, 1);
    chk({tag, " period"}, period, exp_per);
  endtask

  initial begin
    int n;
    wait_n(5); rst = 0; wait_n(2);
    chk("R1 reset locked", locked, 0);
    chk("R1 reset period", period, 0);
    chk("R1 reset request", tx_req, 0);

    give_valid(8'h7F); wait_n(5);
    chk("R9 valid byte ignored in hunt", tx_req, 0);

    send_byte(8'h55, 20); wait_n(40);
    chk("R3 non-reference byte rejected", tx_req, 0);
    chk("R3 still unlocked", locked, 0);
    wait_n(4200);   // pending measurement must expire (R10)

    send_ref(20, 140, 20, 20);
    chk("R2 nothing before decision", locked, 0);
    chk("R5 request raised", tx_req, 1);
    wait_n(30);
    chk("R5 request held without ready", tx_req, 1);
    accept_ack(20, "R2 R10 relock after abandon");

    send_ref(10, 70, 10, 30);
    chk("R9 line ignored while locked, period", period, 20);
    chk("R9 line ignored while locked, request", tx_req, 0);

    for (int i = 0; i < 4; i++) begin wait_n(300); give_valid(8'h41); end
    chk("R7 valid bytes keep lock", locked, 1);

    give_valid(8'h7F);
    chk("R6 nack requested", tx_req, 1);
    chk("R6 nack code 0x15", tx_data, 8'h15);
    chk("R6 lock kept", locked, 1);
    give_valid(8'h7F);
    give_ready; wait_n(1);
    chk("R6 second nack dropped while busy", tx_req, 0);

    give_valid(8'h33);
    n = 0;
    while (locked && n < 5000) begin n++; wait_n(1); end
    chk("R7 lock length after last byte", n, TMO);
    chk("R11 period kept after timeout", period, 20);

    wait_n(5);
    send_ref(37, 259, 37, 37);
    accept_ack(37, "R2 period 37");
    give_fail;
    chk("R8 fail drops lock", locked, 0);
    chk("R8 no nack on fail", tx_req, 0);
    chk("R11 period kept after fail", period, 37);

    wait_n(5);
    send_ref(21, 150, 21, 21);
    accept_ack(21, "R2 truncated 171/8");
    give_fail; wait_n(5);

    send_ref(15, 145, 20, 20);
    accept_ack(20, "R3 start pulse 15 of 20 accepted");
    give_fail; wait_n(5);
    send_ref(14, 146, 20, 20);
    chk("R3 start pulse 14 of 20 rejected", tx_req, 0);
    wait_n(5);
    send_ref(25, 135, 20, 20);
    accept_ack(20, "R3 start pulse 25 of 20 accepted");
    give_fail; wait_n(5);
    send_ref(26, 134, 20, 20);
    chk("R3 start pulse 26 of 20 rejected", tx_req, 0);
    chk("R3 still unlocked after reject", locked, 0);
    wait_n(10);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule